// File: doc/BRIEF.md
# DMX512 Frame Transmitter

This block drives a continuous DMX512 lighting-control stream on a single output line. It holds up to 512 one-byte channel levels in an internal buffer. A host stores a level by giving a 1-based channel address. Frames follow one another without a gap. Each frame has three parts, in this order:

1. A low break.
2. A high mark-after-break.
3. A run of 11-bit slots: a zero start code first, then channels 1 up to the current active channel count.

The active channel count is 16 after reset. Any accepted write to a higher address raises it. A set command can force it to a value, capped at 512. A set value of zero stops the stream: the line then idles high until a write or a non-zero set starts it again. Bit timing comes from a clock-enable tick that divides the system clock down to 250 kHz, so one bit lasts 4 µs. A pulse marks the start of every break, and a busy flag is high while a frame is in progress.

Top module: `dmx512_tx`

## Requirements
- R1: While reset is asserted and in the cycle after it, `dmx_out` is 1, `busy` is 0 and `frame_start` is 0. All channel levels reset to 0.
- R2: Each frame starts with `frame_start` high for one cycle. The line is then low for 22 bit periods (the break), then high for 2 bit periods (the mark-after-break).
- R3: Each slot lasts 11 bit periods: a 0 start bit, 8 data bits sent least significant bit first, then two 1 stop bits. The first slot of each frame carries 0x00.
- R4: A write of level V to address N (1 to 512) is stored at buffer index N-1. Slot N of every later frame carries V.
- R5: Writes to address 0 or to addresses above 512 are ignored. Neither the stored levels nor the active channel count change.
- R6: After reset the active channel count is 16. With no writes, a frame holds the start code plus 16 slots.
- R7: An accepted write to an address above the active count sets the count to that address; a lower address leaves it unchanged. A write while stopped restarts the stream.
- R8: A set command with a non-zero value sets the active count to min(value, 512) and starts the stream if it is stopped. A lower count takes effect in the frame in progress.
- R9: A set command with value 0 stops the stream at the end of the slot in progress. After that, `dmx_out` stays 1, `busy` stays 0 and no `frame_start` appears.
- R10: The next break begins as soon as the last stop bit of the slot numbered with the active count ends. A frame with count M therefore lasts (24 + 11·(M+1)) bit periods.
- R11: One bit period is CLK_HZ/250000 clock cycles. The line changes only on a tick. The first tick, and so the first `frame_start`, comes on the CLK_HZ/250000-th rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Channel write strobe |
| wr_addr | input | ADDR_W | 1-based channel address |
| wr_data | input | 8 | Channel level |
| max_set | input | 1 | Set-count strobe; takes priority over a write-raise in the same cycle |
| max_val | input | ADDR_W | Requested active channel count (0 stops) |
| dmx_out | output | 1 | Serial DMX line |
| frame_start | output | 1 | One-cycle pulse as each break begins |
| busy | output | 1 | High while a frame is being sent |

## Verification
The first `frame_start` is due on the fourth rising edge after reset is released, with the default divide of 4. From then on, bit p of a frame is valid between cycle 4p and cycle 4p+3 after that frame's `frame_start`. The bench samples every bit at offset 4p+2, on a falling edge, away from any transition. It counts cycles between successive `frame_start` pulses and compares the count with the exact length that R10 predicts. Writes and set commands are driven on falling edges and never during a capture. Because of that, the frame after the next `frame_start` must already reflect each stimulus, and the bench's model applies it there.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
    localparam int NCH       = 512;
    localparam int SLOT_BITS = 11;
    localparam int BIT_HZ    = 250000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BREAK,
        ST_MAB,
        ST_SLOT
    } seq_state_t;

    function automatic int unsigned cap_count(input int unsigned v);
        return (v > NCH) ? NCH : v;
    endfunction
endpackage

// File: rtl/dmx_bit_tick.sv
module dmx_bit_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = $clog2(DIV + 1);
    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dmx_chan_store.sv
module dmx_chan_store
    import dmx_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CH_W   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              max_set,
    input  logic [ADDR_W-1:0] max_val,
    input  logic [CH_W-1:0]   rd_slot,
    output logic [7:0]        rd_data,
    output logic [CH_W-1:0]   max_ch
);
    localparam int IDX_W = $clog2(NCH);

    logic [7:0]       lvl [NCH];
    logic             wr_ok;
    logic [IDX_W-1:0] wr_idx;
    logic [CH_W-1:0]  set_cnt;

    assign wr_ok   = wr_en && (wr_addr != '0) && (int'(wr_addr) <= NCH);
    assign wr_idx  = IDX_W'(wr_addr - 1'b1);
    assign rd_data = lvl[rd_slot[IDX_W-1:0]];
    assign set_cnt = CH_W'(cap_count(int'(max_val)));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) lvl[i] <= 8'h00;
        end else if (wr_ok) begin
            lvl[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            max_ch <= CH_W'(16);
        else if (max_set)
            max_ch <= set_cnt;
        else if (wr_ok && (int'(wr_addr) > int'(max_ch)))
            max_ch <= CH_W'(wr_addr);
    end

    AST_COUNT_CAPPED: assert property (@(posedge clk) disable iff (rst)
        int'(max_ch) <= NCH); // R8
    AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !max_set && (wr_addr == '0 || int'(wr_addr) > NCH)) |=> $stable(max_ch)); // R5
    AST_WRITE_RAISES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !max_set && wr_addr != '0 && int'(wr_addr) <= NCH
         && int'(wr_addr) > int'(max_ch)) |=> (max_ch == CH_W'($past(wr_addr)))); // R7
endmodule

// File: rtl/dmx_framer.sv
module dmx_framer
    import dmx_pkg::*;
#(
    parameter int CH_W  = 10,
    parameter int BRK_T = 22,
    parameter int MAB_T = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic [CH_W-1:0] max_ch,
    input  logic [7:0]      rd_data,
    output logic [CH_W-1:0] rd_slot,
    output logic            line,
    output logic            frame_start,
    output logic            busy
);
    localparam int CNT_W = $clog2(BRK_T + MAB_T + 1);

    seq_state_t      state;
    logic [CNT_W-1:0] cnt;
    logic [3:0]       bit_i;
    logic [9:0]       sh;
    logic [CH_W-1:0]  slot;

    assign rd_slot = slot;
    assign busy    = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            bit_i       <= '0;
            sh          <= '1;
            slot        <= '0;
            line        <= 1'b1;
            frame_start <= 1'b0;
        end else begin
            frame_start <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: if (max_ch != '0) begin
                        state       <= ST_BREAK;
                        cnt         <= '0;
                        line        <= 1'b0;
                        frame_start <= 1'b1;
                    end
                    ST_BREAK: if (cnt == CNT_W'(BRK_T - 1)) begin
                        state <= ST_MAB;
                        cnt   <= '0;
                        line  <= 1'b1;
                    end else cnt <= cnt + 1'b1;
                    ST_MAB: if (cnt == CNT_W'(MAB_T - 1)) begin
                        state <= ST_SLOT;
                        slot  <= '0;
                        bit_i <= '0;
                        sh    <= {2'b11, 8'h00};
                        line  <= 1'b0;
                    end else cnt <= cnt + 1'b1;
                    ST_SLOT: if (bit_i == 4'(SLOT_BITS - 1)) begin
                        if (max_ch == '0) begin
                            state <= ST_IDLE;
                            line  <= 1'b1;
                        end else if (slot >= max_ch) begin
                            state       <= ST_BREAK;
                            cnt         <= '0;
                            line        <= 1'b0;
                            frame_start <= 1'b1;
                        end else begin
                            slot  <= slot + 1'b1;
                            bit_i <= '0;
                            sh    <= {2'b11, rd_data};
                            line  <= 1'b0;
                        end
                    end else begin
                        bit_i <= bit_i + 1'b1;
                        line  <= sh[0];
                        sh    <= {1'b1, sh[9:1]};
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> line); // R9
    AST_PULSE_IN_BREAK: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (state == ST_BREAK && !line)); // R2
    AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(line)); // R11
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start); // R2
endmodule

// File: rtl/dmx512_tx.sv
module dmx512_tx
    import dmx_pkg::*;
#(
    parameter int CLK_HZ = 1000000,
    parameter int ADDR_W = 10,
    parameter int BRK_T  = 22,
    parameter int MAB_T  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              max_set,
    input  logic [ADDR_W-1:0] max_val,
    output logic              dmx_out,
    output logic              frame_start,
    output logic              busy
);
    localparam int DIV  = CLK_HZ / BIT_HZ;
    localparam int CH_W = $clog2(NCH + 1);

    logic            tick;
    logic [CH_W-1:0] max_ch;
    logic [CH_W-1:0] rd_slot;
    logic [7:0]      rd_data;

    dmx_bit_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    dmx_chan_store #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .max_set (max_set),
        .max_val (max_val),
        .rd_slot (rd_slot),
        .rd_data (rd_data),
        .max_ch  (max_ch)
    );

    dmx_framer #(.CH_W(CH_W), .BRK_T(BRK_T), .MAB_T(MAB_T)) u_framer (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .max_ch      (max_ch),
        .rd_data     (rd_data),
        .rd_slot     (rd_slot),
        .line        (dmx_out),
        .frame_start (frame_start),
        .busy        (busy)
    );
endmodule

// File: tb/tb_dmx512_tx.sv
module tb_dmx512_tx;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 1000000;
    localparam int BITC       = CLK_HZ / 250000;
    localparam int NCH        = 512;

    // vector: {address, level, expected active count after the write}
    localparam logic [27:0] VEC [0:5] = '{
        {10'd1,   8'hA5, 10'd16},
        {10'd16,  8'h3C, 10'd16},
        {10'd5,   8'h81, 10'd16},
        {10'd20,  8'hFF, 10'd20},
        {10'd0,   8'h77, 10'd20},
        {10'd600, 8'h55, 10'd20}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [9:0] wr_addr;
    logic [7:0] wr_data;
    logic       max_set;
    logic [9:0] max_val;
    logic       dmx_out, frame_start, busy;

    int   n_checks = 0;
    int   n_errors = 0;
    int   cycles   = 0;
    logic [7:0] exp_lvl [NCH];
    int   exp_max;
    logic bitbuf [0:8191];

    always #(CLK_PERIOD/2) clk = ~clk;

    dmx512_tx #(.CLK_HZ(CLK_HZ)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .max_set(max_set), .max_val(max_val),
        .dmx_out(dmx_out), .frame_start(frame_start), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(input int addr, input int data);
        wr_en = 1'b1; wr_addr = 10'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
        if (addr >= 1 && addr <= NCH) begin
            exp_lvl[addr-1] = 8'(data);
            if (addr > exp_max) exp_max = addr;
        end
    endtask

    task automatic do_set(input int v);
        max_set = 1'b1; max_val = 10'(v);
        @(negedge clk);
        max_set = 1'b0;
        exp_max = (v > NCH) ? NCH : v;
    endtask

    task automatic wait_fs();
        int n = 0;
        do begin @(negedge clk); n++; end while (!frame_start && n < 30000);
    endtask

    // called at the falling edge where frame_start is seen; runs up to the next one
    task automatic capture(input string tag);
        int cyc = 0;
        int nb = 24 + 11 * (exp_max + 1);
        int brk_bad = 0, fmt_bad = 0, dat_bad = 0;
        int bad_act = 0, bad_exp = 0;
        do begin
            @(negedge clk); cyc++;
            if ((cyc % BITC) == BITC/2 && (cyc / BITC) < nb) bitbuf[cyc / BITC] = dmx_out;
        end while (!frame_start && cyc < 30000);
        bitbuf[0] = 1'b0;
        for (int p = 0; p < 22; p++) if (bitbuf[p] !== 1'b0) brk_bad++;
        if (bitbuf[22] !== 1'b1 || bitbuf[23] !== 1'b1) brk_bad++;
        for (int s = 0; s <= exp_max; s++) begin
            int b = 24 + 11 * s;
            logic [7:0] got, want;
            if (bitbuf[b] !== 1'b0 || bitbuf[b+9] !== 1'b1 || bitbuf[b+10] !== 1'b1) fmt_bad++;
            for (int k = 0; k < 8; k++) got[k] = bitbuf[b+1+k];
            want = (s == 0) ? 8'h00 : exp_lvl[s-1];
            if (got !== want) begin
                if (dat_bad == 0) begin bad_act = int'(got); bad_exp = int'(want); end
                dat_bad++;
            end
        end
        check(brk_bad == 0, {"R2 break/mab ", tag}, brk_bad, 0);
        check(fmt_bad == 0, {"R3 slot framing ", tag}, fmt_bad, 0);
        check(dat_bad == 0, {"R4 slot data ", tag}, bad_act, bad_exp);
        check(cyc == BITC * nb, {"R10 frame length ", tag}, cyc, BITC * nb);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk); cycles++;
            if (cycles > 190000) begin
                n_errors++; n_checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
                $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
                $finish;
            end
        end
    end

    initial begin : stim
        int n;
        int bad;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; max_set = 1'b0; max_val = '0;
        for (int i = 0; i < NCH; i++) exp_lvl[i] = 8'h00;
        exp_max = 16;
        repeat (3) @(negedge clk);
        check(dmx_out === 1'b1 && busy === 1'b0 && frame_start === 1'b0,
              "R1 reset outputs", int'({dmx_out, busy, frame_start}), 4);
        rst = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!frame_start && n < 100);
        check(n == BITC, "R11 first tick", n, BITC);
        capture("R6 default count");

        for (int v = 0; v < 6; v++) begin
            do_write(int'(VEC[v][27:18]), int'(VEC[v][17:10]));
            check(exp_max == int'(VEC[v][9:0]), "R7 model count", exp_max, int'(VEC[v][9:0]));
            wait_fs();
            capture((v >= 4) ? "R5 ignored write" : "R7 write");
        end

        do_set(0);
        n = 0;
        while (busy && n < 30000) begin @(negedge clk); n++; end
        bad = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (dmx_out !== 1'b1 || busy !== 1'b0 || frame_start !== 1'b0) bad++;
        end
        check(bad == 0, "R9 stopped line", bad, 0);

        do_write(3, 8'h42);
        wait_fs();
        capture("R7 restart by write");

        do_set(0);
        n = 0;
        while (busy && n < 30000) begin @(negedge clk); n++; end
        do_set(700);
        wait_fs();
        capture("R8 capped count");

        do_set(2);
        wait_fs();
        capture("R8 reduced count");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule